// File: doc/BRIEF.md
# APB Watchdog Timer with Key Lock

This peripheral is a 32-bit down-counting watchdog reached through an APB slave port. A separate count-enable input advances the counter by one per enabled cycle. When the counter runs out for the first time, the block raises a raw interrupt flag and starts a fresh period from the reload value. If software has not cleared that flag by the time the next period runs out, the block latches a reset request and halts the counter. Two control bits gate the flag and the latched request onto the interrupt and reset outputs.

Software services the watchdog by writing the interrupt-clear location. It can guard the configuration against stray writes by locking the block: only one magic key written to the lock location reopens it. An integration-test mode lets a register drive both outputs directly, and a bank of read-only identification words describes the part.

A parameter selects a reduced variant. It decodes no test registers, and its control register freezes once the interrupt enable bit has been set, so that only a reset clears it.

Top module: `apb_watchdog_lk`

## Requirements
- R1: The counter decrements by exactly one on each clock edge where `cnt_en` is high and counting is running; with `cnt_en` low it holds. The current count reads at byte offset 0x004.
- R2: The control register at offset 0x008 keeps only bit 0 (interrupt enable) and bit 1 (reset enable); its other bits read as zero.
- R3: A write to offset 0x000 stores the reload value, loads the counter with it and restarts counting, even after a halt. A load or interrupt-clear write takes precedence over a count tick in the same cycle.
- R4: A tick that finds the count at 1 or 0 is an expiry. If the raw flag (offset 0x010, bit 0) is clear, the expiry sets it and reloads the counter from the reload value.
- R5: An expiry while the raw flag is set latches the reset status, sets the counter to 0 and halts counting. Only a reset clears the status.
- R6: Any write to offset 0x00C clears the raw flag and reloads the counter from the reload value. It does not restart a halted counter.
- R7: `irq_o` equals the raw flag AND control bit 0, and `rst_req_o` equals the reset status AND control bit 1. Offset 0x014 reads the gated interrupt in bit 0.
- R8: Writing 32'h1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it; the location reads 1 when locked. While locked, writes to every other offset are ignored.
- R9: With test control (offset 0xF00) bit 0 set, `irq_o` follows test output (offset 0xF04) bit 1 and `rst_req_o` follows its bit 0, whatever the status path holds.
- R10: After reset, control, raw flag, reset status, lock, test control and test output are zero, and the reload value and the counter are 32'hFFFFFFFF with counting running.
- R11: Reads of undecoded offsets and of the write-only offsets 0x00C and 0xF04 return zero. Writes to the read-only offsets 0x004, 0x010 and 0x014 change nothing.
- R12: With `STICKY_CTRL` set, offsets 0xF00 and 0xF04 are undecoded (they read zero and writes do nothing), and control writes are ignored once control bit 0 is 1.
- R13: Identification word i (i = 0 to 11) sits at offset 0xFD0 + 4*i and reads 8'hA0 + i in bits 7:0 (8'hC0 + i in the sticky variant), with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while a read is selected |
| cnt_en | input | 1 | Count enable, one decrement per high cycle |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
A register write takes effect at the clock edge that ends its access phase. Read data is combinational during the access phase. A count tick changes the counter, the raw flag or the reset status at that same edge, and the interrupt and reset outputs follow those registers with no further delay. The bench's reference model advances at every rising edge from the same inputs the design sees. It compares both outputs of both instances half a cycle later, and it samples read data in the middle of each access phase against the model's state from the preceding edge. Targeted checks pin exact counts, such as three ticks from a load of 100 reading 97, and the cycles of the first and second expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // word offsets (byte offset / 4)
    localparam logic [9:0] W_LOAD     = 10'h000;
    localparam logic [9:0] W_COUNT    = 10'h001;
    localparam logic [9:0] W_CTRL     = 10'h002;
    localparam logic [9:0] W_ICLR     = 10'h003;
    localparam logic [9:0] W_RAW      = 10'h004;
    localparam logic [9:0] W_MASKED   = 10'h005;
    localparam logic [9:0] W_LOCK     = 10'h300;
    localparam logic [9:0] W_TCTL     = 10'h3C0;
    localparam logic [9:0] W_TOUT     = 10'h3C1;
    localparam logic [9:0] W_ID_FIRST = 10'h3F4;
    localparam logic [9:0] W_ID_LAST  = 10'h3FF;

    typedef struct packed {
        logic rst_en;   // bit 1
        logic irq_en;   // bit 0
    } ctrl_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic variant);
        return (variant ? 8'hC0 : 8'hA0) + {4'h0, idx};
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             pend_i,
    output logic [CNT_W-1:0] count_o,
    output logic             first_o,
    output logic             final_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        first_o = 1'b0;
        final_o = 1'b0;
        if (load_wr) begin
            st_d.cnt = load_val;
            st_d.run = 1'b1;
        end else if (reload_req) begin
            st_d.cnt = reload_val;
        end else if (st_q.run && tick_en) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                if (!pend_i) begin
                    first_o  = 1'b1;
                    st_d.cnt = reload_val;
                end else begin
                    final_o  = 1'b1;
                    st_d.run = 1'b0;
                    st_d.cnt = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                WORD_AW = 10,
    parameter int                STICKY = 0,
    parameter logic [DATA_W-1:0] KEY = 32'h1ACCE551
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [WORD_AW-1:0] word_i,
    input  logic [DATA_W-1:0]  pwdata,
    input  logic [DATA_W-1:0]  count_i,
    input  logic               first_i,
    input  logic               final_i,
    output logic [DATA_W-1:0]  prdata,
    output logic               load_wr_o,
    output logic               iclr_o,
    output logic [DATA_W-1:0]  load_o,
    output logic               raw_o,
    output logic               rstat_o,
    output logic               lock_o,
    output ctrl_t              ctrl_o,
    output logic               tctl_o,
    output logic [1:0]         tout_o
);

    localparam bit HAS_TEST = (STICKY == 0);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        ctrl_t             ctrl;
        logic              raw;
        logic              rstat;
        logic              lock;
        logic              tctl;
        logic [1:0]        tout;
    } reg_st_t;

    reg_st_t r_d, r_q;
    logic    wr, open;
    logic    hit_load, hit_ctrl, hit_iclr, hit_lock, hit_tctl, hit_tout, hit_id;
    logic [3:0] id_ofs;

    assign hit_load = (word_i == WORD_AW'(W_LOAD));
    assign hit_ctrl = (word_i == WORD_AW'(W_CTRL));
    assign hit_iclr = (word_i == WORD_AW'(W_ICLR));
    assign hit_lock = (word_i == WORD_AW'(W_LOCK));
    assign hit_tctl = HAS_TEST && (word_i == WORD_AW'(W_TCTL));
    assign hit_tout = HAS_TEST && (word_i == WORD_AW'(W_TOUT));
    assign hit_id   = (word_i >= WORD_AW'(W_ID_FIRST)) && (word_i <= WORD_AW'(W_ID_LAST));
    assign id_ofs   = 4'(word_i - WORD_AW'(W_ID_FIRST));

    assign wr        = psel && penable && pwrite;
    assign open      = wr && !r_q.lock;
    assign load_wr_o = open && hit_load;
    assign iclr_o    = open && hit_iclr;

    always_comb begin
        r_d = r_q;
        if (load_wr_o) r_d.load = pwdata;
        if (open && hit_ctrl && !((STICKY != 0) && r_q.ctrl.irq_en))
            r_d.ctrl = ctrl_t'(pwdata[1:0]);
        if (wr && hit_lock) r_d.lock = (pwdata != KEY);
        if (open && hit_tctl) r_d.tctl = pwdata[0];
        if (open && hit_tout) r_d.tout = pwdata[1:0];
        if (iclr_o)       r_d.raw = 1'b0;
        else if (first_i) r_d.raw = 1'b1;
        if (final_i) r_d.rstat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.load  <= '1;
            r_q.ctrl  <= '0;
            r_q.raw   <= 1'b0;
            r_q.rstat <= 1'b0;
            r_q.lock  <= 1'b0;
            r_q.tctl  <= 1'b0;
            r_q.tout  <= 2'b00;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit_load)                              prdata = r_q.load;
            else if (word_i == WORD_AW'(W_COUNT))      prdata = count_i;
            else if (hit_ctrl)                         prdata = DATA_W'(r_q.ctrl);
            else if (word_i == WORD_AW'(W_RAW))        prdata = DATA_W'(r_q.raw);
            else if (word_i == WORD_AW'(W_MASKED))     prdata = DATA_W'(r_q.raw && r_q.ctrl.irq_en);
            else if (hit_lock)                         prdata = DATA_W'(r_q.lock);
            else if (hit_tctl)                         prdata = DATA_W'(r_q.tctl);
            else if (hit_id)                           prdata = DATA_W'(id_byte(id_ofs, STICKY != 0));
        end
    end

    assign load_o  = r_q.load;
    assign raw_o   = r_q.raw;
    assign rstat_o = r_q.rstat;
    assign lock_o  = r_q.lock;
    assign ctrl_o  = r_q.ctrl;
    assign tctl_o  = r_q.tctl;
    assign tout_o  = r_q.tout;

endmodule

// File: rtl/wdt_outsel.sv
module wdt_outsel
    import wdt_pkg::*;
#(
    parameter bit HAS_TEST = 1'b1
) (
    input  logic       raw_i,
    input  logic       rstat_i,
    input  ctrl_t      ctrl_i,
    input  logic       tctl_i,
    input  logic [1:0] tout_i,
    output logic       irq_o,
    output logic       rst_o
);

    logic irq_norm, rst_norm;
    assign irq_norm = raw_i && ctrl_i.irq_en;
    assign rst_norm = rstat_i && ctrl_i.rst_en;

    generate
        if (HAS_TEST) begin : g_test
            assign irq_o = tctl_i ? tout_i[1] : irq_norm;
            assign rst_o = tctl_i ? tout_i[0] : rst_norm;
        end else begin : g_plain
            logic unused_test;
            assign unused_test = tctl_i ^ (^tout_i);
            assign irq_o = irq_norm;
            assign rst_o = rst_norm;
        end
    endgenerate

endmodule

// File: rtl/apb_watchdog_lk.sv
module apb_watchdog_lk
    import wdt_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 12,
    parameter int                STICKY_CTRL = 0,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cnt_en,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int WORD_AW = ADDR_W - 2;

    logic [WORD_AW-1:0] word_w;
    logic [DATA_W-1:0]  count_w, load_w;
    logic               first_w, final_w, load_wr_w, iclr_w;
    logic               raw_w, rstat_w, lock_w, tctl_w;
    logic [1:0]         tout_w;
    ctrl_t              ctrl_w;
    logic               unused_lsb;

    assign word_w     = paddr[ADDR_W-1:2];
    assign unused_lsb = ^paddr[1:0];

    wdt_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk        (pclk),
        .rst_n      (presetn),
        .tick_en    (cnt_en),
        .load_wr    (load_wr_w),
        .load_val   (pwdata),
        .reload_req (iclr_w),
        .reload_val (load_w),
        .pend_i     (raw_w),
        .count_o    (count_w),
        .first_o    (first_w),
        .final_o    (final_w)
    );

    wdt_regs #(
        .DATA_W  (DATA_W),
        .WORD_AW (WORD_AW),
        .STICKY  (STICKY_CTRL),
        .KEY     (UNLOCK_KEY)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .word_i    (word_w),
        .pwdata    (pwdata),
        .count_i   (count_w),
        .first_i   (first_w),
        .final_i   (final_w),
        .prdata    (prdata),
        .load_wr_o (load_wr_w),
        .iclr_o    (iclr_w),
        .load_o    (load_w),
        .raw_o     (raw_w),
        .rstat_o   (rstat_w),
        .lock_o    (lock_w),
        .ctrl_o    (ctrl_w),
        .tctl_o    (tctl_w),
        .tout_o    (tout_w)
    );

    wdt_outsel #(.HAS_TEST(STICKY_CTRL == 0)) u_out (
        .raw_i   (raw_w),
        .rstat_i (rstat_w),
        .ctrl_i  (ctrl_w),
        .tctl_i  (tctl_w),
        .tout_i  (tout_w),
        .irq_o   (irq_o),
        .rst_o   (rst_req_o)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_AW = 10,
    parameter int STICKY = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [WORD_AW-1:0] word,
    input logic [DATA_W-1:0]  pwdata,
    input logic [DATA_W-1:0]  prdata,
    input logic [DATA_W-1:0]  count,
    input logic [DATA_W-1:0]  load,
    input logic               load_wr,
    input logic               iclr,
    input logic               first,
    input logic               fin,
    input logic               raw,
    input logic               rstat,
    input logic               locked,
    input ctrl_t              ctrl,
    input logic               tctl,
    input logic               irq,
    input logic               rst_req
);

    p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && word == WORD_AW'(W_CTRL)) |-> (prdata[DATA_W-1:2] == '0));

    p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count == $past(pwdata)));

    p_first_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        first |=> (raw && count == $past(load)));

    p_final_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (rstat && count == '0));

    p_clear_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iclr |=> !raw);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tctl |-> (irq == (raw && ctrl.irq_en)));

    p_rst_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tctl |-> (rst_req == (rstat && ctrl.rst_en)));

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && psel && penable && pwrite && word != WORD_AW'(W_LOCK))
            |=> ($stable(ctrl) && $stable(load) && $stable(tctl)));

    p_sticky_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((STICKY != 0) && ctrl.irq_en) |=> ctrl.irq_en);

endmodule

bind apb_watchdog_lk wdt_checker #(
    .DATA_W  (DATA_W),
    .WORD_AW (WORD_AW),
    .STICKY  (STICKY_CTRL)
) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .word    (word_w),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .count   (count_w),
    .load    (load_w),
    .load_wr (load_wr_w),
    .iclr    (iclr_w),
    .first   (first_w),
    .fin     (final_w),
    .raw     (raw_w),
    .rstat   (rstat_w),
    .locked  (lock_w),
    .ctrl    (ctrl_w),
    .tctl    (tctl_w),
    .irq     (irq_o),
    .rst_req (rst_req_o)
);

// File: tb/tb_apb_watchdog_lk.sv
`timescale 1ns/1ps
module tb_apb_watchdog_lk;

    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic [1:0]  psel = 2'b00;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        cnt_en = 1'b0;
    logic [31:0] prd [2];
    logic [1:0]  irq, rsq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(TCK/2) clk = ~clk;

    apb_watchdog_lk dut (
        .pclk(clk), .presetn(presetn), .psel(psel[0]), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prd[0]),
        .cnt_en(cnt_en), .irq_o(irq[0]), .rst_req_o(rsq[0])
    );

    apb_watchdog_lk #(.STICKY_CTRL(1)) dut_v (
        .pclk(clk), .presetn(presetn), .psel(psel[1]), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prd[1]),
        .cnt_en(cnt_en), .irq_o(irq[1]), .rst_req_o(rsq[1])
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_load [2];
    logic [31:0] m_cnt  [2];
    bit          m_run [2], m_raw [2], m_rs [2], m_lock [2], m_tctl [2];
    bit [1:0]    m_ctrl [2], m_tout [2];

    task automatic model_reset(int k);
        m_load[k] = 32'hFFFF_FFFF; m_cnt[k] = 32'hFFFF_FFFF; m_run[k] = 1;
        m_raw[k] = 0; m_rs[k] = 0; m_lock[k] = 0; m_tctl[k] = 0;
        m_ctrl[k] = 0; m_tout[k] = 0;
    endtask

    task automatic model_step(int k);
        bit wr    = psel[k] && penable && pwrite;
        int w     = int'(paddr[11:2]);
        bit open  = wr && !m_lock[k];
        bit tests = (k == 0);
        bit first = 0;
        bit fin   = 0;
        if (open && w == 0) begin
            m_cnt[k] = pwdata; m_run[k] = 1;
        end else if (open && w == 3) begin
            m_cnt[k] = m_load[k];
        end else if (m_run[k] && cnt_en) begin
            if (m_cnt[k] <= 1) begin
                if (!m_raw[k]) begin first = 1; m_cnt[k] = m_load[k]; end
                else begin fin = 1; m_run[k] = 0; m_cnt[k] = 0; end
            end else m_cnt[k] = m_cnt[k] - 1;
        end
        if (open && w == 0) m_load[k] = pwdata;
        if (open && w == 2 && !(k == 1 && m_ctrl[k][0])) m_ctrl[k] = pwdata[1:0];
        if (wr && w == 'h300) m_lock[k] = (pwdata != 32'h1ACC_E551);
        if (tests && open && w == 'h3C0) m_tctl[k] = pwdata[0];
        if (tests && open && w == 'h3C1) m_tout[k] = pwdata[1:0];
        if (open && w == 3) m_raw[k] = 0;
        else if (first) m_raw[k] = 1;
        if (fin) m_rs[k] = 1;
    endtask

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!presetn) model_reset(k);
            else model_step(k);
        end
    end

    function automatic bit exp_irq(int k);
        return (k == 0 && m_tctl[k]) ? m_tout[k][1] : (m_raw[k] && m_ctrl[k][0]);
    endfunction

    function automatic bit exp_rst(int k);
        return (k == 0 && m_tctl[k]) ? m_tout[k][0] : (m_rs[k] && m_ctrl[k][1]);
    endfunction

    function automatic logic [31:0] exp_rd(int k, int w);
        if (w == 0)        return m_load[k];
        if (w == 1)        return m_cnt[k];
        if (w == 2)        return {30'd0, m_ctrl[k]};
        if (w == 4)        return {31'd0, m_raw[k]};
        if (w == 5)        return {31'd0, m_raw[k] && m_ctrl[k][0]};
        if (w == 'h300)    return {31'd0, m_lock[k]};
        if (w == 'h3C0)    return (k == 0) ? {31'd0, m_tctl[k]} : 32'd0;
        if (w >= 'h3F4 && w <= 'h3FF)
            return {24'd0, ((k == 0) ? 8'hA0 : 8'hC0) + 8'(w - 'h3F4)};
        return 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // every-cycle output comparison (R7, R9)
    always @(negedge clk) begin
        if (presetn && !done) begin
            #2;
            for (int k = 0; k < 2; k++) begin
                check($sformatf("R7/R9 irq inst%0d", k), {31'd0, irq[k]}, {31'd0, exp_irq(k)});
                check($sformatf("R7/R9 rst inst%0d", k), {31'd0, rsq[k]}, {31'd0, exp_rst(k)});
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic apb_wr(int k, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        psel[k] = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 2'b00; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(int k, logic [11:0] a, string req, output logic [31:0] got);
        @(negedge clk);
        psel[k] = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2;
        got = prd[k];
        check(req, got, exp_rd(k, int'(a[11:2])));
        @(negedge clk);
        psel = 2'b00; penable = 1'b0;
    endtask

    task automatic ticks(int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        repeat (3) @(negedge clk);
        presetn = 1'b1;

        // R10 reset state
        for (int k = 0; k < 2; k++) begin
            apb_rd(k, 12'h000, "R10 load", v);  check("R10 load literal", v, 32'hFFFF_FFFF);
            apb_rd(k, 12'h004, "R10 count", v); check("R10 count literal", v, 32'hFFFF_FFFF);
            apb_rd(k, 12'h008, "R10 ctrl", v);  check("R10 ctrl literal", v, 0);
            apb_rd(k, 12'h010, "R10 raw", v);
            apb_rd(k, 12'hC00, "R10 lock", v);  check("R10 lock literal", v, 0);
        end

        // R2 control bits
        apb_wr(0, 12'h008, 32'hFFFF_FFFF);
        apb_rd(0, 12'h008, "R2 ctrl", v); check("R2 ctrl literal", v, 32'd3);

        // R1 / R3 counting after a load
        apb_wr(0, 12'h000, 32'd100);
        apb_rd(0, 12'h004, "R3 count after load", v); check("R3 literal", v, 32'd100);
        ticks(3);
        apb_rd(0, 12'h004, "R1 count", v); check("R1 three ticks", v, 32'd97);

        // R4 first expiry, R7 masked read
        apb_wr(0, 12'h000, 32'd2);
        ticks(2);
        apb_rd(0, 12'h010, "R4 raw", v);    check("R4 raw literal", v, 32'd1);
        apb_rd(0, 12'h004, "R4 reload", v); check("R4 reload literal", v, 32'd2);
        apb_rd(0, 12'h014, "R7 masked", v); check("R7 masked literal", v, 32'd1);
        check("R7 irq literal", {31'd0, irq[0]}, 32'd1);

        // R6 clear
        apb_wr(0, 12'h00C, 32'h0);
        apb_rd(0, 12'h010, "R6 raw cleared", v); check("R6 literal", v, 32'd0);

        // R5 two expiries without service
        ticks(4);
        apb_rd(0, 12'h004, "R5 halted count", v); check("R5 count zero", v, 32'd0);
        check("R5 rst literal", {31'd0, rsq[0]}, 32'd1);
        apb_wr(0, 12'h00C, 32'h0);
        ticks(3);
        apb_rd(0, 12'h004, "R6 no restart", v); check("R6 held at load", v, 32'd2);
        check("R5 status sticky", {31'd0, rsq[0]}, 32'd1);
        apb_wr(0, 12'h000, 32'd50);
        ticks(5);
        apb_rd(0, 12'h004, "R3 restart", v); check("R3 restart literal", v, 32'd45);

        // R3 precedence: load write while ticking
        cnt_en = 1'b1;
        apb_wr(0, 12'h000, 32'd9);
        cnt_en = 1'b0;
        apb_rd(0, 12'h004, "R3 precedence", v);

        // R8 lock
        apb_wr(0, 12'hC00, 32'h0);
        apb_rd(0, 12'hC00, "R8 locked", v); check("R8 lock reads 1", v, 32'd1);
        apb_wr(0, 12'h008, 32'h0);
        apb_wr(0, 12'h000, 32'd777);
        apb_rd(0, 12'h008, "R8 ctrl held", v); check("R8 ctrl literal", v, 32'd3);
        apb_rd(0, 12'h000, "R8 load held", v); check("R8 load literal", v, 32'd9);
        apb_wr(0, 12'hC00, 32'h1ACC_E551);
        apb_rd(0, 12'hC00, "R8 unlocked", v); check("R8 unlock literal", v, 32'd0);
        apb_wr(0, 12'h008, 32'h1);
        apb_rd(0, 12'h008, "R8 ctrl open", v); check("R8 ctrl open literal", v, 32'd1);

        // R9 test override
        apb_wr(0, 12'hF00, 32'h1);
        apb_wr(0, 12'hF04, 32'h2);
        check("R9 irq from test", {31'd0, irq[0]}, 32'd1);
        check("R9 rst from test", {31'd0, rsq[0]}, 32'd0);
        apb_wr(0, 12'hF04, 32'h1);
        check("R9 irq from test b", {31'd0, irq[0]}, 32'd0);
        check("R9 rst from test b", {31'd0, rsq[0]}, 32'd1);
        apb_rd(0, 12'hF00, "R9 tctl read", v); check("R9 tctl literal", v, 32'd1);
        apb_wr(0, 12'hF00, 32'h0);

        // R11 write-only, undecoded, read-only
        apb_rd(0, 12'hF04, "R11 tout reads 0", v); check("R11 tout literal", v, 32'd0);
        apb_rd(0, 12'h00C, "R11 iclr reads 0", v); check("R11 iclr literal", v, 32'd0);
        apb_rd(0, 12'h100, "R11 undecoded", v);    check("R11 undecoded literal", v, 32'd0);
        apb_rd(0, 12'h004, "R11 count before", v0);
        apb_wr(0, 12'h004, 32'h55);
        apb_wr(0, 12'h010, 32'h1);
        apb_rd(0, 12'h004, "R11 count after", v); check("R11 ro write", v, v0);

        // R13 identification words
        apb_rd(0, 12'hFD0, "R13 id0", v);  check("R13 id0 literal", v, 32'hA0);
        apb_rd(0, 12'hFFC, "R13 id11", v); check("R13 id11 literal", v, 32'hAB);
        apb_rd(1, 12'hFE4, "R13 var id5", v); check("R13 var literal", v, 32'hC5);

        // R12 variant
        apb_wr(1, 12'h008, 32'h2);
        apb_rd(1, 12'h008, "R12 ctrl writable", v); check("R12 literal a", v, 32'd2);
        apb_wr(1, 12'h008, 32'h1);
        apb_wr(1, 12'h008, 32'h0);
        apb_rd(1, 12'h008, "R12 ctrl sticky", v); check("R12 literal b", v, 32'd1);
        apb_wr(1, 12'hF00, 32'h1);
        apb_wr(1, 12'hF04, 32'h3);
        apb_rd(1, 12'hF00, "R12 no tctl", v); check("R12 tctl literal", v, 32'd0);
        check("R12 irq not overridden", {31'd0, irq[1]}, 32'd0);
        apb_wr(1, 12'h000, 32'd1);
        ticks(1);
        check("R12 irq from status", {31'd0, irq[1]}, 32'd1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        #3;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule